// File: doc/BRIEF.md
# Auto-Rewinding Frame Buffer Streamer

This block feeds a display pixel engine from a packed frame buffer held in ordinary synchronous memory. It walks the buffer one byte per transfer, issuing a read to the memory port and then handing the returned byte to the pixel engine's input FIFO. The destination never changes. Only the read address advances. A transfer is issued only in a cycle where the FIFO signals that it has room. At the default geometry a frame is 640 by 480 pixels at two pixels per byte, which is 153600 bytes.

Streaming starts when the enable input is first seen high after reset. At that moment the configured base address and byte count are captured. After the last byte of a frame has been read, a reload step writes the captured base back into the read pointer. The remaining count is refilled in the same cycle, so the next frame begins at once with no outside action. The display is refreshed for as long as the block runs.

The memory has a fixed read latency of one cycle. Each byte is written to the FIFO in the cycle after it returns. The FIFO's request must therefore leave room for the two bytes that can still be in flight when the request drops.

Top module: `fbuf_stream`

## Requirements
- R1: After reset the block issues no memory read and no FIFO write until enable is seen high. A configured count of zero keeps it idle even while enabled.
- R2: Streaming starts in the clock edge where enable is first sampled high. The first read follows in the next cycle. From then on, exactly one read is issued in each cycle where both enable and fifo_req are high, and none in any other cycle.
- R3: The first read address is the captured base. Each later read uses the previous address plus one.
- R4: After a read of the last byte of a frame (read number count), the next read uses the captured base again and the count restarts in full. No byte is skipped or repeated. With a count of one, every read uses the base.
- R5: Every read produces exactly one FIFO write, two cycles after the read cycle. The write carries the byte the memory returned one cycle after that read.
- R6: Changes to cfg_base and cfg_count after streaming has started have no effect on the addresses read.
- R7: While enable is low after streaming has started, no reads occur and the position is kept. When enable returns high, reading resumes at the next unread address.
- R8: With the full 153600-byte frame, the read that follows the read of base+153599 is at the base address, and the stream continues in order from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Starts streaming on first sight; low pauses it |
| cfg_base | input | 24 | Frame buffer base address, captured at start |
| cfg_count | input | 18 | Bytes per frame, captured at start |
| fifo_req | input | 1 | Downstream FIFO has room and requests data |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 24 | Memory read address |
| mem_data | input | 8 | Read data, valid one cycle after mem_rd |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | Byte written to the FIFO |

## Verification
The bench targets the frame boundary. It uses small counts that wrap several times in a burst, a count of one, and the full 153600-byte frame. A design with an off-by-one in the reload would either read one address past the frame or read the base twice. Patterned and single-cycle requests expose reads issued without a request and writes placed a cycle early or late. Pausing mid-frame catches a pointer that drifts while idle. Rewriting the configuration during streaming catches a design that reads the live inputs at reload instead of the captured values. A zero count shows whether the block starts a stream whose counter would underflow.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
   localparam int unsigned H_ACTIVE     = 640;
   localparam int unsigned V_ACTIVE     = 480;
   localparam int unsigned PIX_PER_BYTE = 2;
   localparam int unsigned FRAME_BYTES  = H_ACTIVE * V_ACTIVE / PIX_PER_BYTE;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_e;
endpackage

// File: rtl/fbs_addr_gen.sv
module fbs_addr_gen
   import fbs_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              fifo_req,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [CNT_W-1:0]  cfg_count,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              running
);

   run_state_e        state_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  rem_q;
   logic              last_byte;

   assign running   = (state_q == ST_RUN);
   assign rd_en     = running && enable && fifo_req;
   assign rd_addr   = ptr_q;
   assign last_byte = (rem_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         ptr_q   <= '0;
         count_q <= '0;
         rem_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (enable && (cfg_count != '0)) begin
                  base_q  <= cfg_base;
                  ptr_q   <= cfg_base;
                  count_q <= cfg_count;
                  rem_q   <= cfg_count;
                  state_q <= ST_RUN;
               end
            end
            default: begin
               if (rd_en) begin
                  if (last_byte) begin
                     ptr_q <= base_q;
                     rem_q <= count_q;
                  end else begin
                     ptr_q <= ptr_q + ADDR_W'(1);
                     rem_q <= rem_q - CNT_W'(1);
                  end
               end
            end
         endcase
      end
   end

   AST_REM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (rem_q != '0) && (rem_q <= count_q)); // R4
   AST_PTR_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> ((ptr_q - base_q) == ADDR_W'(count_q - rem_q))); // R3
   AST_HOLD_WHEN_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !rd_en) |=> ($stable(ptr_q) && $stable(rem_q))); // R7
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> ($stable(base_q) && $stable(count_q))); // R6

endmodule

// File: rtl/fbs_rd_pipe.sv
module fbs_rd_pipe #(
   parameter int DATA_W = 8,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] mem_data,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data
);

   logic              tap;
   logic              wr_q;
   logic [DATA_W-1:0] data_q;

   if (RD_LAT == 1) begin : g_lat_one
      logic vld_q;
      always_ff @(posedge clk) begin
         if (!rst_n) vld_q <= 1'b0;
         else        vld_q <= rd_en;
      end
      assign tap = vld_q;
   end else begin : g_lat_many
      logic [RD_LAT-1:0] vld_q;
      always_ff @(posedge clk) begin
         if (!rst_n) vld_q <= '0;
         else        vld_q <= {vld_q[RD_LAT-2:0], rd_en};
      end
      assign tap = vld_q[RD_LAT-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= 1'b0;
         data_q <= '0;
      end else begin
         wr_q <= tap;
         if (tap) data_q <= mem_data;
      end
   end

   assign wr_en   = wr_q;
   assign wr_data = data_q;

endmodule

// File: rtl/fbuf_stream.sv
module fbuf_stream
   import fbs_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int DATA_W      = 8,
   parameter int FRAME_LEN   = FRAME_BYTES,
   parameter int CNT_W       = $clog2(FRAME_LEN + 1),
   parameter int RD_LAT      = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              fifo_req,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_data,
   output logic              fifo_wr,
   output logic [DATA_W-1:0] fifo_data
);

   if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr
      $error("fbuf_stream: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("fbuf_stream: DATA_W must be positive");
   end
   if (RD_LAT < 1 || RD_LAT > 8) begin : g_bad_lat
      $error("fbuf_stream: RD_LAT must be 1 to 8");
   end
   if (CNT_W < 1 || CNT_W > 32 || (64'(1) << CNT_W) <= 64'(FRAME_LEN)) begin : g_bad_cnt
      $error("fbuf_stream: CNT_W cannot hold FRAME_LEN");
   end

   logic running;

   fbs_addr_gen #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_addr_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .fifo_req  (fifo_req),
      .cfg_base  (cfg_base),
      .cfg_count (cfg_count),
      .rd_en     (mem_rd),
      .rd_addr   (mem_addr),
      .running   (running)
   );

   fbs_rd_pipe #(
      .DATA_W (DATA_W),
      .RD_LAT (RD_LAT)
   ) u_rd_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (mem_rd),
      .mem_data (mem_data),
      .wr_en    (fifo_wr),
      .wr_data  (fifo_data)
   );

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !fifo_wr); // R1

   if (RD_LAT == 1) begin : g_wr_chk
      AST_WRITE_TWO_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
         fifo_wr == $past(mem_rd, 2)); // R5
   end

endmodule

// File: tb/fbuf_stream_bench.sv
`timescale 1ns/1ps
module fbuf_stream_bench;

   localparam int AW = 24;
   localparam int DW = 8;
   localparam int CW = 18;
   localparam int FULL = 153600;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic [AW-1:0] cfg_base = '0;
   logic [CW-1:0] cfg_count = '0;
   logic          fifo_req = 1'b0;
   logic          mem_rd;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_data = '0;
   logic          fifo_wr;
   logic [DW-1:0] fifo_data;

   always #10 clk = ~clk;

   fbuf_stream u_fbuf_stream (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_base(cfg_base),
      .cfg_count(cfg_count), .fifo_req(fifo_req), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_data(mem_data), .fifo_wr(fifo_wr),
      .fifo_data(fifo_data)
   );

   function automatic logic [7:0] mem_f(logic [AW-1:0] a);
      return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16];
   endfunction

   always_ff @(posedge clk) begin
      if (mem_rd) mem_data <= mem_f(mem_addr);
   end

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int reads, writes, addr_err, data_err, noreq_err, wrap_ok, wrap_bad;
   logic [AW-1:0] exp_addr, mon_base, wrap_addr;
   int mon_count, mon_rem;
   bit after_last;
   logic [7:0] expq[$];

   task automatic mon_init(logic [AW-1:0] b, int c);
      reads = 0; writes = 0; addr_err = 0; data_err = 0; noreq_err = 0;
      wrap_ok = 0; wrap_bad = 0; wrap_addr = '0; after_last = 0;
      mon_base = b; mon_count = c; mon_rem = c; exp_addr = b;
      expq.delete();
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (fifo_wr) begin
            writes++;
            if (expq.size() == 0) data_err++;
            else if (fifo_data != expq.pop_front()) data_err++;
         end
         if (mem_rd) begin
            reads++;
            if (!(enable && fifo_req)) noreq_err++;
            if (mem_addr != exp_addr) addr_err++;
            if (after_last) begin
               if (mem_addr == mon_base) wrap_ok++;
               else wrap_bad++;
               wrap_addr = mem_addr;
            end
            after_last = (mon_rem == 1);
            expq.push_back(mem_f(mem_addr));
            if (mon_rem == 1) begin
               exp_addr = mon_base;
               mon_rem = mon_count;
            end else begin
               exp_addr = exp_addr + 1'b1;
               mon_rem--;
            end
         end
      end
   end

   task automatic check(bit ok, string tag, longint act, longint expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; enable = 1'b0; fifo_req = 1'b0;
      tick(3);
      rst_n = 1'b1;
   endtask

   typedef struct packed {
      logic [AW-1:0] base;
      logic [CW-1:0] count;
      logic [15:0]   mask;
      logic [7:0]    exp_reads;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{base: 24'h000100, count: 18'd5, mask: 16'hFFFF, exp_reads: 8'd16},
      '{base: 24'hABCDE0, count: 18'd3, mask: 16'hAAAA, exp_reads: 8'd8},
      '{base: 24'h0000FE, count: 18'd7, mask: 16'h00F0, exp_reads: 8'd4},
      '{base: 24'h123456, count: 18'd1, mask: 16'hFFFF, exp_reads: 8'd16}
   };

   initial begin
      #(64'd4000000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: idle after reset, enable low, request high
      mon_init('0, 1);
      do_reset();
      fifo_req = 1'b1;
      tick(1);
      check(!mem_rd && !fifo_wr, "R1 reset outputs quiet", {mem_rd, fifo_wr}, 0);
      tick(8);
      check(reads == 0 && writes == 0, "R1 no traffic while disabled", reads + writes, 0);

      // R1: zero count stays idle
      do_reset();
      mon_init('0, 1);
      cfg_base = 24'h000010; cfg_count = '0; enable = 1'b1; fifo_req = 1'b1;
      tick(8);
      check(reads == 0, "R1 zero count idle", reads, 0);

      // Table walk: R3 R4 R5 R6 R2
      for (int i = 0; i < 4; i++) begin
         do_reset();
         cfg_base = VECS[i].base; cfg_count = VECS[i].count;
         mon_init(VECS[i].base, int'(VECS[i].count));
         enable = 1'b1;
         tick(1);
         cfg_base = ~VECS[i].base; cfg_count = 18'd2;   // R6: must be ignored
         for (int k = 0; k < 16; k++) begin
            fifo_req = VECS[i].mask[k];
            tick(1);
         end
         fifo_req = 1'b0;
         tick(4);
         check(reads == int'(VECS[i].exp_reads) && noreq_err == 0,
               $sformatf("R2 vec%0d read count", i), reads, VECS[i].exp_reads);
         check(addr_err == 0, $sformatf("R3 R4 R6 vec%0d address order", i), addr_err, 0);
         check(writes == reads, $sformatf("R5 vec%0d write count", i), writes, reads);
         check(data_err == 0, $sformatf("R5 vec%0d write data", i), data_err, 0);
      end

      // R2 R5: start latency and write timing for a single read
      do_reset();
      cfg_base = 24'h0000AB; cfg_count = 18'd4;
      mon_init(24'h0000AB, 4);
      enable = 1'b1; fifo_req = 1'b1;
      @(negedge clk);
      check(!mem_rd, "R2 no read in start cycle", mem_rd, 0);
      @(negedge clk);
      check(mem_rd && mem_addr == 24'h0000AB, "R2 first read at base", mem_addr, 24'h0000AB);
      @(posedge clk); #1;
      fifo_req = 1'b0;
      @(negedge clk);
      check(!fifo_wr, "R5 no write one cycle after read", fifo_wr, 0);
      @(negedge clk);
      check(fifo_wr && fifo_data == mem_f(24'h0000AB), "R5 write two cycles after read",
            fifo_data, mem_f(24'h0000AB));
      @(negedge clk);
      check(!fifo_wr, "R5 single write per read", fifo_wr, 0);

      // R7: pause keeps position
      do_reset();
      cfg_base = 24'h000200; cfg_count = 18'd10;
      mon_init(24'h000200, 10);
      enable = 1'b1; fifo_req = 1'b1;
      tick(1);
      tick(3);
      check(reads == 3, "R7 reads before pause", reads, 3);
      enable = 1'b0;
      tick(5);
      check(reads == 3, "R7 no reads while paused", reads, 3);
      enable = 1'b1;
      tick(3);
      fifo_req = 1'b0;
      tick(4);
      check(reads == 6 && addr_err == 0, "R7 resume at next address", addr_err, 0);
      check(writes == 6 && data_err == 0, "R7 data after resume", data_err, 0);

      // R8: full frame wrap
      do_reset();
      cfg_base = 24'h040000; cfg_count = CW'(FULL);
      mon_init(24'h040000, FULL);
      enable = 1'b1; fifo_req = 1'b1;
      tick(1);
      tick(FULL + 10);
      fifo_req = 1'b0;
      tick(4);
      check(reads == FULL + 10 && noreq_err == 0, "R8 reads over frame", reads, FULL + 10);
      check(addr_err == 0, "R8 address order across wrap", addr_err, 0);
      check(wrap_ok == 1 && wrap_bad == 0, "R8 one clean wrap", wrap_ok, 1);
      check(wrap_addr == 24'h040000, "R8 byte 0 follows last byte", wrap_addr, 24'h040000);
      check(writes == reads && data_err == 0, "R8 data across wrap", data_err, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule